// File: doc/BRIEF.md
# RV32I Instruction Decode Unit

This block turns one 32-bit instruction word into a flat execute-command record for the next pipeline stage. The record selects the ALU operands and operation, picks the operands of the separate address adder, gives a load/store command, a CSR operand and operation, and the source that writes the destination register. It also raises single-bit requests for jump, conditional branch, return-from-trap, instruction-fence and wait-for-interrupt, and carries the three register addresses, a 32-bit immediate and an exception request with a cause code.

The decoder is purely combinational: the command appears in the same cycle as the instruction. Some record fields are reused to keep the record narrow. For immediate-form CSR operations the rs1 field holds the 5-bit unsigned immediate. For every CSR operation the immediate output holds the funct3 field above the 12-bit CSR address. When an instruction is illegal, the immediate output returns the raw instruction word so the trap handler can report it.

Only the base integer set is decoded. A 16-bit compressed word is detected from its low two bits and flagged, but not expanded. With the default parameter it is reported as illegal. With `ALLOW_RVC=1` it passes as a quiet record with no commands.

Top module: `rvid_top`

## Requirements
- R1: `rvc_o` is 1 exactly when `instr_i[1:0]` is not 2'b11. With the default `ALLOW_RVC=0` such a word raises the illegal-instruction exception.
- R2: An illegal word sets `exc_o`=1 and `exc_code_o`=2, drives every command field to 0 (NONE), clears all five request flags and copies `instr_i` to `imm_o`. An illegal word is an unlisted major opcode in bits [6:2], an unused funct3/funct7 combination, or a compressed word when `ALLOW_RVC=0`.
- R3: Register-register (opcode 0110011) and register-immediate (opcode 0010011) operations set `alu_cmd_o` with NONE=0, AND=1, OR=2, XOR=3, ADD=4, SUB=5, LT=6, LTU=7, SLL=12, SRL=13, SRA=14. `alu_opsel_o` is 1 for register-register and 0 for register-immediate, and `wb_sel_o`=1. Instruction bit 30 selects SUB over ADD and SRA over SRL. `rs1_o`, `rs2_o` and `rd_o` are bits [19:15], [24:20] and [11:7].
- R4: Loads set `lsu_cmd_o` LB=1, LH=2, LW=3, LBU=4, LHU=5 with `wb_sel_o`=5. Stores set SB=6, SH=7, SW=8 with `wb_sel_o`=0. Both set `adr_opsel_o`=1 (rs1 plus immediate). Load funct3 values 3, 6 and 7 are illegal.
- R5: I-type and S-type immediates are sign-extended from 12 bits to 32 bits.
- R6: Branches set `branch_o`, `adr_opsel_o`=0 (PC plus immediate) and `alu_opsel_o`=1. `alu_cmd_o` is EQ=8, NE=9, LT=6, GE=10, LTU=7 or GEU=11 for funct3 0, 1, 4, 5, 6, 7. Funct3 2 and 3 are illegal. The B-type immediate is sign-extended and its bit 0 is 0.
- R7: LUI sets `wb_sel_o`=3. AUIPC sets `wb_sel_o`=2 with `adr_opsel_o`=0. Both place the U-type immediate (bits [31:12] over twelve zeros) on `imm_o`.
- R8: JAL sets `jump_o`, `adr_opsel_o`=0, `wb_sel_o`=4 and a sign-extended J-type immediate with bit 0 equal to 0. JALR with funct3 0 sets `jump_o`, `adr_opsel_o`=1, `wb_sel_o`=4 and an I-type immediate.
- R9: CSR operations set `csr_cmd_o` WRITE=1, SET=2, CLEAR=3 for funct3 bits [1:0] of 1, 2, 3. `csr_opsel_o` is 0 for the immediate forms (funct3 bit 2 set) and 1 for the register forms, and `wb_sel_o`=6. `imm_o` is {17 zeros, funct3, bits [31:20]}, and `rs1_o` carries the 5-bit immediate. Funct3 4 is illegal.
- R10: MRET (0x30200073) sets only `mret_o`. WFI (0x10500073) sets only `wfi_o`. Fence-instruction (funct3 1 of opcode 0001111) sets only `fencei_o`. A plain fence (funct3 0) yields an all-NONE record with no exception.
- R11: ECALL raises `exc_o` with `exc_code_o`=11, and EBREAK raises it with `exc_code_o`=3. Neither sets any command field.
- R12: At most one of `jump_o`, `branch_o`, `mret_o`, `fencei_o`, `wfi_o` is 1 for any input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_i | input | 32 | Instruction word to decode |
| rvc_o | output | 1 | Word is a 16-bit compressed encoding |
| alu_opsel_o | output | 1 | ALU second operand: 0 immediate, 1 rs2 |
| alu_cmd_o | output | 4 | ALU operation |
| adr_opsel_o | output | 1 | Address adder base: 0 PC, 1 rs1 |
| lsu_cmd_o | output | 4 | Load/store command |
| csr_opsel_o | output | 1 | CSR source: 0 immediate, 1 rs1 |
| csr_cmd_o | output | 2 | CSR operation |
| wb_sel_o | output | 3 | Destination register write source |
| jump_o | output | 1 | Unconditional jump request |
| branch_o | output | 1 | Conditional branch request |
| mret_o | output | 1 | Return-from-trap request |
| fencei_o | output | 1 | Instruction fence request |
| wfi_o | output | 1 | Wait-for-interrupt request |
| rs1_o | output | 5 | First source register (CSR immediate for immediate forms) |
| rs2_o | output | 5 | Second source register |
| rd_o | output | 5 | Destination register |
| imm_o | output | 32 | Immediate, CSR descriptor or raw illegal word |
| exc_o | output | 1 | Exception request |
| exc_code_o | output | 4 | Exception cause code |

## Verification
The block holds no state, so any decode fault is visible on the ports in the same cycle that the word is presented. There is no later cycle in which it could be masked or corrected. A bad opcode or funct match shows up in one of three ways: a wrong command code, a missing or doubled request flag, or an exception raised or lost. A wrong immediate-format choice shows as a wrongly placed or wrongly extended `imm_o`. Each directed word is therefore paired with exact expected values for every field it should set and for the fields it must leave at NONE.

// File: rtl/rvid_pkg.sv
// Package rvid_pkg
// Shared encodings for the instruction decoder. Numeric values are part of
// the command record consumed downstream and must not be reordered.
package rvid_pkg;

    localparam int XLEN      = 32;
    localparam int REG_AW    = 5;
    localparam int EXC_W     = 4;

    localparam logic [EXC_W-1:0] EXC_ILLEGAL = 4'd2;
    localparam logic [EXC_W-1:0] EXC_BREAK   = 4'd3;
    localparam logic [EXC_W-1:0] EXC_ECALL   = 4'd11;

    // major opcodes, instruction bits [6:2]
    localparam logic [4:0] OPC_LOAD   = 5'b00000;
    localparam logic [4:0] OPC_FENCE  = 5'b00011;
    localparam logic [4:0] OPC_ARI    = 5'b00100;
    localparam logic [4:0] OPC_AUIPC  = 5'b00101;
    localparam logic [4:0] OPC_STORE  = 5'b01000;
    localparam logic [4:0] OPC_ARR    = 5'b01100;
    localparam logic [4:0] OPC_LUI    = 5'b01101;
    localparam logic [4:0] OPC_BR     = 5'b11000;
    localparam logic [4:0] OPC_JALR   = 5'b11001;
    localparam logic [4:0] OPC_JAL    = 5'b11011;
    localparam logic [4:0] OPC_SYS    = 5'b11100;

    typedef enum logic [0:0] { ALU_SRC_IMM = 1'b0, ALU_SRC_REG = 1'b1 } alu_src_e;

    typedef enum logic [3:0] {
        ALU_NONE = 4'd0,  ALU_AND = 4'd1,  ALU_OR  = 4'd2,  ALU_XOR = 4'd3,
        ALU_ADD  = 4'd4,  ALU_SUB = 4'd5,  ALU_LT  = 4'd6,  ALU_LTU = 4'd7,
        ALU_EQ   = 4'd8,  ALU_NE  = 4'd9,  ALU_GE  = 4'd10, ALU_GEU = 4'd11,
        ALU_SLL  = 4'd12, ALU_SRL = 4'd13, ALU_SRA = 4'd14
    } alu_cmd_e;

    typedef enum logic [0:0] { ADR_PC = 1'b0, ADR_RS1 = 1'b1 } adr_src_e;

    typedef enum logic [3:0] {
        MEM_NONE = 4'd0, MEM_LB = 4'd1, MEM_LH = 4'd2, MEM_LW = 4'd3,
        MEM_LBU  = 4'd4, MEM_LHU = 4'd5, MEM_SB = 4'd6, MEM_SH = 4'd7,
        MEM_SW   = 4'd8
    } mem_cmd_e;

    typedef enum logic [0:0] { CSRSRC_IMM = 1'b0, CSRSRC_REG = 1'b1 } csr_src_e;

    typedef enum logic [1:0] {
        CSRC_NONE = 2'd0, CSRC_WRITE = 2'd1, CSRC_SET = 2'd2, CSRC_CLEAR = 2'd3
    } csr_cmd_e;

    typedef enum logic [2:0] {
        WB_NONE = 3'd0, WB_ALU = 3'd1, WB_ADDER = 3'd2, WB_IMM = 3'd3,
        WB_LINK = 3'd4, WB_MEM = 3'd5, WB_CSR = 3'd6
    } wb_src_e;

    // immediate layout chosen by the control decoder
    typedef enum logic [2:0] {
        IMF_ZERO = 3'd0, IMF_I = 3'd1, IMF_S = 3'd2, IMF_B = 3'd3,
        IMF_U    = 3'd4, IMF_J = 3'd5, IMF_CSR = 3'd6
    } imm_fmt_e;

    typedef struct packed {
        alu_src_e          alu_src;
        alu_cmd_e          alu_cmd;
        adr_src_e          adr_src;
        mem_cmd_e          mem_cmd;
        csr_src_e          csr_src;
        csr_cmd_e          csr_cmd;
        wb_src_e           wb_src;
        logic              jump;
        logic              branch;
        logic              mret;
        logic              fencei;
        logic              wfi;
        imm_fmt_e          imm_fmt;
        logic              illegal;
        logic              trap;
        logic [EXC_W-1:0]  trap_code;
    } ctl_t;

endpackage

// File: rtl/rvid_imm_gen.sv
// Module rvid_imm_gen
// Assembles the 32-bit immediate from instruction bits [31:7] in the layout
// selected by the control decoder. Assumes fmt is a valid imm_fmt_e value;
// any other value yields zero.
module rvid_imm_gen
    import rvid_pkg::*;
(
    input  logic [31:7]     word_i,
    input  imm_fmt_e        fmt_i,
    output logic [XLEN-1:0] imm_o
);

    localparam int SEXT_I = XLEN - 12;
    localparam int SEXT_B = XLEN - 13;
    localparam int SEXT_J = XLEN - 21;
    localparam int CSR_PAD = XLEN - 15;

    logic [XLEN-1:0] imm_i, imm_s, imm_b, imm_u, imm_j, imm_csr;

    // per-format bit gathering, all formats in parallel
    always_comb begin
        imm_i   = {{SEXT_I{word_i[31]}}, word_i[31:20]};
        imm_s   = {{SEXT_I{word_i[31]}}, word_i[31:25], word_i[11:7]};
        imm_b   = {{SEXT_B{word_i[31]}}, word_i[31], word_i[7], word_i[30:25],
                   word_i[11:8], 1'b0};
        imm_u   = {word_i[31:12], 12'h000};
        imm_j   = {{SEXT_J{word_i[31]}}, word_i[31], word_i[19:12], word_i[20],
                   word_i[30:21], 1'b0};
        imm_csr = {{CSR_PAD{1'b0}}, word_i[14:12], word_i[31:20]};
    end

    // final format select
    always_comb begin
        unique case (fmt_i)
            IMF_I:   imm_o = imm_i;
            IMF_S:   imm_o = imm_s;
            IMF_B:   imm_o = imm_b;
            IMF_U:   imm_o = imm_u;
            IMF_J:   imm_o = imm_j;
            IMF_CSR: imm_o = imm_csr;
            default: imm_o = '0;
        endcase
    end

    // alignment of control-flow offsets
    always_comb begin
        if (fmt_i == IMF_B || fmt_i == IMF_J)
            assert_even_target_R6: assert (imm_o[0] == 1'b0)
                else $error("branch/jump immediate is odd");
    end

endmodule

// File: rtl/rvid_ctl_dec.sv
// Module rvid_ctl_dec
// Decodes a full-length base-integer instruction (bits [31:2]) into control
// fields. Assumes the caller has already confirmed bits [1:0] == 2'b11; the
// illegal flag covers only opcode and funct checks.
module rvid_ctl_dec
    import rvid_pkg::*;
(
    input  logic [31:2] word_i,
    output ctl_t        ctl_o
);

    logic [4:0]  opc;
    logic [2:0]  f3;
    logic [6:0]  f7;
    logic [11:0] f12;
    logic        regs_zero;

    // field extraction
    always_comb begin
        opc       = word_i[6:2];
        f3        = word_i[14:12];
        f7        = word_i[31:25];
        f12       = word_i[31:20];
        regs_zero = (word_i[19:15] == '0) && (word_i[11:7] == '0);
    end

    // main opcode / funct decode
    always_comb begin
        ctl_o = '{alu_src: ALU_SRC_IMM, alu_cmd: ALU_NONE, adr_src: ADR_PC,
                  mem_cmd: MEM_NONE, csr_src: CSRSRC_IMM, csr_cmd: CSRC_NONE,
                  wb_src: WB_NONE, jump: 1'b0, branch: 1'b0, mret: 1'b0,
                  fencei: 1'b0, wfi: 1'b0, imm_fmt: IMF_ZERO, illegal: 1'b0,
                  trap: 1'b0, trap_code: '0};
        unique case (opc)
            OPC_LOAD: begin
                ctl_o.adr_src = ADR_RS1;
                ctl_o.wb_src  = WB_MEM;
                ctl_o.imm_fmt = IMF_I;
                case (f3)
                    3'd0: ctl_o.mem_cmd = MEM_LB;
                    3'd1: ctl_o.mem_cmd = MEM_LH;
                    3'd2: ctl_o.mem_cmd = MEM_LW;
                    3'd4: ctl_o.mem_cmd = MEM_LBU;
                    3'd5: ctl_o.mem_cmd = MEM_LHU;
                    default: ctl_o.illegal = 1'b1;
                endcase
            end
            OPC_STORE: begin
                ctl_o.adr_src = ADR_RS1;
                ctl_o.imm_fmt = IMF_S;
                case (f3)
                    3'd0: ctl_o.mem_cmd = MEM_SB;
                    3'd1: ctl_o.mem_cmd = MEM_SH;
                    3'd2: ctl_o.mem_cmd = MEM_SW;
                    default: ctl_o.illegal = 1'b1;
                endcase
            end
            OPC_ARI: begin
                ctl_o.alu_src = ALU_SRC_IMM;
                ctl_o.wb_src  = WB_ALU;
                ctl_o.imm_fmt = IMF_I;
                case (f3)
                    3'd0: ctl_o.alu_cmd = ALU_ADD;
                    3'd2: ctl_o.alu_cmd = ALU_LT;
                    3'd3: ctl_o.alu_cmd = ALU_LTU;
                    3'd4: ctl_o.alu_cmd = ALU_XOR;
                    3'd6: ctl_o.alu_cmd = ALU_OR;
                    3'd7: ctl_o.alu_cmd = ALU_AND;
                    3'd1: begin
                        ctl_o.alu_cmd = ALU_SLL;
                        if (f7 != 7'b0000000) ctl_o.illegal = 1'b1;
                    end
                    default: begin
                        ctl_o.alu_cmd = f7[5] ? ALU_SRA : ALU_SRL;
                        if ({f7[6], f7[4:0]} != 6'd0) ctl_o.illegal = 1'b1;
                    end
                endcase
            end
            OPC_ARR: begin
                ctl_o.alu_src = ALU_SRC_REG;
                ctl_o.wb_src  = WB_ALU;
                case (f3)
                    3'd0: ctl_o.alu_cmd = f7[5] ? ALU_SUB : ALU_ADD;
                    3'd1: ctl_o.alu_cmd = ALU_SLL;
                    3'd2: ctl_o.alu_cmd = ALU_LT;
                    3'd3: ctl_o.alu_cmd = ALU_LTU;
                    3'd4: ctl_o.alu_cmd = ALU_XOR;
                    3'd5: ctl_o.alu_cmd = f7[5] ? ALU_SRA : ALU_SRL;
                    3'd6: ctl_o.alu_cmd = ALU_OR;
                    default: ctl_o.alu_cmd = ALU_AND;
                endcase
                if ({f7[6], f7[4:0]} != 6'd0) ctl_o.illegal = 1'b1;
                if (f7[5] && f3 != 3'd0 && f3 != 3'd5) ctl_o.illegal = 1'b1;
            end
            OPC_LUI: begin
                ctl_o.wb_src  = WB_IMM;
                ctl_o.imm_fmt = IMF_U;
            end
            OPC_AUIPC: begin
                ctl_o.adr_src = ADR_PC;
                ctl_o.wb_src  = WB_ADDER;
                ctl_o.imm_fmt = IMF_U;
            end
            OPC_JAL: begin
                ctl_o.jump    = 1'b1;
                ctl_o.adr_src = ADR_PC;
                ctl_o.wb_src  = WB_LINK;
                ctl_o.imm_fmt = IMF_J;
            end
            OPC_JALR: begin
                ctl_o.jump    = 1'b1;
                ctl_o.adr_src = ADR_RS1;
                ctl_o.wb_src  = WB_LINK;
                ctl_o.imm_fmt = IMF_I;
                if (f3 != 3'd0) ctl_o.illegal = 1'b1;
            end
            OPC_BR: begin
                ctl_o.branch  = 1'b1;
                ctl_o.adr_src = ADR_PC;
                ctl_o.alu_src = ALU_SRC_REG;
                ctl_o.imm_fmt = IMF_B;
                case (f3)
                    3'd0: ctl_o.alu_cmd = ALU_EQ;
                    3'd1: ctl_o.alu_cmd = ALU_NE;
                    3'd4: ctl_o.alu_cmd = ALU_LT;
                    3'd5: ctl_o.alu_cmd = ALU_GE;
                    3'd6: ctl_o.alu_cmd = ALU_LTU;
                    3'd7: ctl_o.alu_cmd = ALU_GEU;
                    default: ctl_o.illegal = 1'b1;
                endcase
            end
            OPC_FENCE: begin
                case (f3)
                    3'd0: ;
                    3'd1: ctl_o.fencei = 1'b1;
                    default: ctl_o.illegal = 1'b1;
                endcase
            end
            OPC_SYS: begin
                if (f3 == 3'd0) begin
                    if (!regs_zero) ctl_o.illegal = 1'b1;
                    else begin
                        case (f12)
                            12'h000: begin ctl_o.trap = 1'b1; ctl_o.trap_code = EXC_ECALL; end
                            12'h001: begin ctl_o.trap = 1'b1; ctl_o.trap_code = EXC_BREAK; end
                            12'h302: ctl_o.mret = 1'b1;
                            12'h105: ctl_o.wfi  = 1'b1;
                            default: ctl_o.illegal = 1'b1;
                        endcase
                    end
                end else if (f3 == 3'd4) begin
                    ctl_o.illegal = 1'b1;
                end else begin
                    ctl_o.wb_src  = WB_CSR;
                    ctl_o.imm_fmt = IMF_CSR;
                    ctl_o.csr_src = f3[2] ? CSRSRC_IMM : CSRSRC_REG;
                    case (f3[1:0])
                        2'd1:    ctl_o.csr_cmd = CSRC_WRITE;
                        2'd2:    ctl_o.csr_cmd = CSRC_SET;
                        default: ctl_o.csr_cmd = CSRC_CLEAR;
                    endcase
                end
            end
            default: ctl_o.illegal = 1'b1;
        endcase
    end

    // memory commands and their address source agree
    always_comb begin
        if (!ctl_o.illegal && ctl_o.mem_cmd != MEM_NONE)
            assert_mem_uses_rs1_R4: assert (ctl_o.adr_src == ADR_RS1)
                else $error("memory command without rs1 base");
    end

endmodule

// File: rtl/rvid_top.sv
// Module rvid_top
// Combinational base-integer decoder. Detects compressed words, runs the
// control decoder and immediate generator, then applies the illegal and
// compressed overrides to form the command record.
// ALLOW_RVC: 0 reports compressed words as illegal, 1 passes them quietly.
module rvid_top
    import rvid_pkg::*;
#(
    parameter bit ALLOW_RVC = 1'b0
)
(
    input  logic [31:0]        instr_i,
    output logic               rvc_o,
    output logic               alu_opsel_o,
    output logic [3:0]         alu_cmd_o,
    output logic               adr_opsel_o,
    output logic [3:0]         lsu_cmd_o,
    output logic               csr_opsel_o,
    output logic [1:0]         csr_cmd_o,
    output logic [2:0]         wb_sel_o,
    output logic               jump_o,
    output logic               branch_o,
    output logic               mret_o,
    output logic               fencei_o,
    output logic               wfi_o,
    output logic [REG_AW-1:0]  rs1_o,
    output logic [REG_AW-1:0]  rs2_o,
    output logic [REG_AW-1:0]  rd_o,
    output logic [XLEN-1:0]    imm_o,
    output logic               exc_o,
    output logic [EXC_W-1:0]   exc_code_o
);

    ctl_t            ctl;
    logic [XLEN-1:0] imm_raw;
    logic            is_short;
    logic            short_ok;
    logic            bad;

    rvid_ctl_dec u_ctl (
        .word_i (instr_i[31:2]),
        .ctl_o  (ctl)
    );

    rvid_imm_gen u_imm (
        .word_i (instr_i[31:7]),
        .fmt_i  (ctl.imm_fmt),
        .imm_o  (imm_raw)
    );

    // compressed-word policy chosen at elaboration
    generate
        if (ALLOW_RVC) begin : g_rvc_pass
            assign short_ok = 1'b1;
        end else begin : g_rvc_trap
            assign short_ok = 1'b0;
        end
    endgenerate

    // length detection and legality
    always_comb begin
        is_short = (instr_i[1:0] != 2'b11);
        bad      = is_short ? !short_ok : ctl.illegal;
    end

    // record assembly with illegal / compressed overrides
    always_comb begin
        rvc_o = is_short;
        rs1_o = instr_i[19:15];
        rs2_o = instr_i[24:20];
        rd_o  = instr_i[11:7];
        if (bad || is_short) begin
            alu_opsel_o = ALU_SRC_IMM;
            alu_cmd_o   = ALU_NONE;
            adr_opsel_o = ADR_PC;
            lsu_cmd_o   = MEM_NONE;
            csr_opsel_o = CSRSRC_IMM;
            csr_cmd_o   = CSRC_NONE;
            wb_sel_o    = WB_NONE;
            jump_o      = 1'b0;
            branch_o    = 1'b0;
            mret_o      = 1'b0;
            fencei_o    = 1'b0;
            wfi_o       = 1'b0;
            imm_o       = bad ? instr_i : '0;
            exc_o       = bad;
            exc_code_o  = bad ? EXC_ILLEGAL : '0;
        end else begin
            alu_opsel_o = ctl.alu_src;
            alu_cmd_o   = ctl.alu_cmd;
            adr_opsel_o = ctl.adr_src;
            lsu_cmd_o   = ctl.mem_cmd;
            csr_opsel_o = ctl.csr_src;
            csr_cmd_o   = ctl.csr_cmd;
            wb_sel_o    = ctl.wb_src;
            jump_o      = ctl.jump;
            branch_o    = ctl.branch;
            mret_o      = ctl.mret;
            fencei_o    = ctl.fencei;
            wfi_o       = ctl.wfi;
            imm_o       = imm_raw;
            exc_o       = ctl.trap;
            exc_code_o  = ctl.trap_code;
        end
    end

    // port-level consistency checks
    always_comb begin
        assert_one_request_R12: assert ($onehot0({jump_o, branch_o, mret_o, fencei_o, wfi_o}))
            else $error("more than one control request");
        if (exc_o)
            assert_exc_quiet_R2: assert (alu_cmd_o == 4'd0 && lsu_cmd_o == 4'd0 &&
                                         csr_cmd_o == 2'd0 && wb_sel_o == 3'd0 &&
                                         !jump_o && !branch_o && !mret_o && !fencei_o && !wfi_o)
                else $error("exception with live command");
        if (exc_o && exc_code_o == EXC_ILLEGAL)
            assert_illegal_word_R2: assert (imm_o == instr_i)
                else $error("illegal word not returned");
        if (csr_cmd_o != 2'd0)
            assert_csr_record_R9: assert (wb_sel_o == 3'd6 && imm_o[XLEN-1:15] == '0 &&
                                          imm_o[14:12] == instr_i[14:12])
                else $error("CSR record malformed");
        if (rvc_o && !ALLOW_RVC)
            assert_short_trap_R1: assert (exc_o && exc_code_o == EXC_ILLEGAL)
                else $error("compressed word not trapped");
        if (branch_o)
            assert_branch_pc_R6: assert (adr_opsel_o == 1'b0 && alu_opsel_o == 1'b1)
                else $error("branch operand selects wrong");
    end

endmodule

// File: tb/sim_rvid_top.sv
module sim_rvid_top;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic [31:0] instr;
    logic        rvc, alu_opsel, adr_opsel, csr_opsel;
    logic [3:0]  alu_cmd, lsu_cmd, exc_code;
    logic [1:0]  csr_cmd;
    logic [2:0]  wb_sel;
    logic        jump, branch, mret, fencei, wfi, exc;
    logic [4:0]  rs1, rs2, rd;
    logic [31:0] imm;

    int n_chk  = 0;
    int n_fail = 0;

    rvid_top u0 (
        .instr_i(instr), .rvc_o(rvc), .alu_opsel_o(alu_opsel), .alu_cmd_o(alu_cmd),
        .adr_opsel_o(adr_opsel), .lsu_cmd_o(lsu_cmd), .csr_opsel_o(csr_opsel),
        .csr_cmd_o(csr_cmd), .wb_sel_o(wb_sel), .jump_o(jump), .branch_o(branch),
        .mret_o(mret), .fencei_o(fencei), .wfi_o(wfi), .rs1_o(rs1), .rs2_o(rs2),
        .rd_o(rd), .imm_o(imm), .exc_o(exc), .exc_code_o(exc_code)
    );

    // encoders
    function automatic logic [31:0] enc_r(logic [6:0] f7, logic [4:0] s2, logic [4:0] s1,
                                          logic [2:0] f3, logic [4:0] d, logic [6:0] op);
        return {f7, s2, s1, f3, d, op};
    endfunction
    function automatic logic [31:0] enc_i(logic [11:0] im, logic [4:0] s1, logic [2:0] f3,
                                          logic [4:0] d, logic [6:0] op);
        return {im, s1, f3, d, op};
    endfunction
    function automatic logic [31:0] enc_s(logic [11:0] im, logic [4:0] s2, logic [4:0] s1,
                                          logic [2:0] f3);
        return {im[11:5], s2, s1, f3, im[4:0], 7'h23};
    endfunction
    function automatic logic [31:0] enc_b(logic [12:0] im, logic [4:0] s2, logic [4:0] s1,
                                          logic [2:0] f3);
        return {im[12], im[10:5], s2, s1, f3, im[4:1], im[11], 7'h63};
    endfunction
    function automatic logic [31:0] enc_j(logic [20:0] im, logic [4:0] d);
        return {im[20], im[10:1], im[11], im[19:12], d, 7'h6F};
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic put(input logic [31:0] w);
        @(posedge clk);
        #1 instr = w;
        @(negedge clk);
    endtask

    task automatic chk_quiet(input string req);
        chk(req, "alu_cmd", {28'd0, alu_cmd}, 32'd0);
        chk(req, "lsu_cmd", {28'd0, lsu_cmd}, 32'd0);
        chk(req, "csr_cmd", {30'd0, csr_cmd}, 32'd0);
        chk(req, "wb_sel",  {29'd0, wb_sel}, 32'd0);
        chk(req, "flags", {27'd0, jump, branch, mret, fencei, wfi}, 32'd0);
    endtask

    task automatic chk_illegal(input string req, input logic [31:0] w);
        put(w);
        chk(req, "exc", {31'd0, exc}, 32'd1);
        chk(req, "exc_code", {28'd0, exc_code}, 32'd2);
        chk(req, "imm raw", imm, w);
        chk_quiet(req);
    endtask

    task automatic t_idle;
        put(32'h0000_0013);
        chk("R3", "nop alu", {28'd0, alu_cmd}, 32'd4);
        chk("R3", "nop exc", {31'd0, exc}, 32'd0);
        chk("R1", "nop rvc", {31'd0, rvc}, 32'd0);
    endtask

    task automatic t_regreg;
        put(enc_r(7'h00, 5'd2, 5'd1, 3'd0, 5'd3, 7'h33));
        chk("R3", "add cmd", {28'd0, alu_cmd}, 32'd4);
        chk("R3", "add opsel", {31'd0, alu_opsel}, 32'd1);
        chk("R3", "add wb", {29'd0, wb_sel}, 32'd1);
        chk("R3", "regs", {17'd0, rs1, rs2, rd}, {17'd0, 5'd1, 5'd2, 5'd3});
        put(enc_r(7'h20, 5'd2, 5'd1, 3'd0, 5'd3, 7'h33));
        chk("R3", "sub cmd", {28'd0, alu_cmd}, 32'd5);
        put(enc_r(7'h20, 5'd7, 5'd8, 3'd5, 5'd9, 7'h33));
        chk("R3", "sra cmd", {28'd0, alu_cmd}, 32'd14);
        put(enc_r(7'h00, 5'd7, 5'd8, 3'd5, 5'd9, 7'h33));
        chk("R3", "srl cmd", {28'd0, alu_cmd}, 32'd13);
        put(enc_r(7'h00, 5'd7, 5'd8, 3'd3, 5'd9, 7'h33));
        chk("R3", "sltu cmd", {28'd0, alu_cmd}, 32'd7);
        chk_illegal("R2", enc_r(7'h20, 5'd7, 5'd8, 3'd7, 5'd9, 7'h33));
    endtask

    task automatic t_regimm;
        put(enc_i(12'hFFB, 5'd6, 3'd0, 5'd5, 7'h13));
        chk("R5", "addi imm", imm, 32'hFFFF_FFFB);
        chk("R3", "addi opsel", {31'd0, alu_opsel}, 32'd0);
        put(enc_i({7'h20, 5'd3}, 5'd2, 3'd5, 5'd1, 7'h13));
        chk("R3", "srai cmd", {28'd0, alu_cmd}, 32'd14);
        put(enc_i(12'h0F0, 5'd2, 3'd7, 5'd1, 7'h13));
        chk("R3", "andi cmd", {28'd0, alu_cmd}, 32'd1);
        chk("R5", "andi imm", imm, 32'h0000_00F0);
        chk_illegal("R2", enc_i({7'h20, 5'd3}, 5'd2, 3'd1, 5'd1, 7'h13));
    endtask

    task automatic t_mem;
        put(enc_i(12'h010, 5'd4, 3'd0, 5'd5, 7'h03));
        chk("R4", "lb cmd", {28'd0, lsu_cmd}, 32'd1);
        chk("R4", "lb wb", {29'd0, wb_sel}, 32'd5);
        chk("R4", "lb adr", {31'd0, adr_opsel}, 32'd1);
        put(enc_i(12'h800, 5'd4, 3'd5, 5'd5, 7'h03));
        chk("R4", "lhu cmd", {28'd0, lsu_cmd}, 32'd5);
        chk("R5", "lhu imm", imm, 32'hFFFF_F800);
        put(enc_s(12'hFF8, 5'd9, 5'd2, 3'd2));
        chk("R4", "sw cmd", {28'd0, lsu_cmd}, 32'd8);
        chk("R4", "sw wb", {29'd0, wb_sel}, 32'd0);
        chk("R5", "sw imm", imm, 32'hFFFF_FFF8);
        put(enc_s(12'h123, 5'd9, 5'd2, 3'd1));
        chk("R4", "sh cmd", {28'd0, lsu_cmd}, 32'd7);
        chk("R5", "sh imm", imm, 32'h0000_0123);
        chk_illegal("R4", enc_i(12'h010, 5'd4, 3'd3, 5'd5, 7'h03));
    endtask

    task automatic t_branch;
        put(enc_b(13'h1FFC, 5'd2, 5'd1, 3'd0));
        chk("R6", "beq cmd", {28'd0, alu_cmd}, 32'd8);
        chk("R6", "beq flag", {31'd0, branch}, 32'd1);
        chk("R6", "beq adr", {31'd0, adr_opsel}, 32'd0);
        chk("R6", "beq imm", imm, 32'hFFFF_FFFC);
        put(enc_b(13'h07FE, 5'd2, 5'd1, 3'd7));
        chk("R6", "bgeu cmd", {28'd0, alu_cmd}, 32'd11);
        chk("R6", "bgeu imm", imm, 32'h0000_07FE);
        put(enc_b(13'h0800, 5'd2, 5'd1, 3'd5));
        chk("R6", "bge cmd", {28'd0, alu_cmd}, 32'd10);
        chk("R6", "bge imm", imm, 32'h0000_0800);
        chk_illegal("R6", enc_b(13'h0010, 5'd2, 5'd1, 3'd2));
    endtask

    task automatic t_upper;
        put({20'hABCDE, 5'd7, 7'h37});
        chk("R7", "lui wb", {29'd0, wb_sel}, 32'd3);
        chk("R7", "lui imm", imm, 32'hABCD_E000);
        put({20'h00012, 5'd7, 7'h17});
        chk("R7", "auipc wb", {29'd0, wb_sel}, 32'd2);
        chk("R7", "auipc adr", {31'd0, adr_opsel}, 32'd0);
        chk("R7", "auipc imm", imm, 32'h0001_2000);
    endtask

    task automatic t_jump;
        put(enc_j(21'h1FFFFE, 5'd1));
        chk("R8", "jal flag", {31'd0, jump}, 32'd1);
        chk("R8", "jal wb", {29'd0, wb_sel}, 32'd4);
        chk("R8", "jal adr", {31'd0, adr_opsel}, 32'd0);
        chk("R8", "jal imm", imm, 32'hFFFF_FFFE);
        put(enc_j(21'h0A5A5A, 5'd1));
        chk("R8", "jal imm2", imm, 32'h000A_5A5A);
        put(enc_i(12'h004, 5'd1, 3'd0, 5'd0, 7'h67));
        chk("R8", "jalr flag", {31'd0, jump}, 32'd1);
        chk("R8", "jalr adr", {31'd0, adr_opsel}, 32'd1);
        chk("R8", "jalr wb", {29'd0, wb_sel}, 32'd4);
        chk("R8", "jalr imm", imm, 32'h0000_0004);
    endtask

    task automatic t_csr;
        put(enc_i(12'h305, 5'd2, 3'd1, 5'd1, 7'h73));
        chk("R9", "csrrw cmd", {30'd0, csr_cmd}, 32'd1);
        chk("R9", "csrrw op", {31'd0, csr_opsel}, 32'd1);
        chk("R9", "csrrw wb", {29'd0, wb_sel}, 32'd6);
        chk("R9", "csrrw imm", imm, 32'h0000_1305);
        put(enc_i(12'h340, 5'd17, 3'd6, 5'd4, 7'h73));
        chk("R9", "csrrsi cmd", {30'd0, csr_cmd}, 32'd2);
        chk("R9", "csrrsi op", {31'd0, csr_opsel}, 32'd0);
        chk("R9", "csrrsi zimm", {27'd0, rs1}, 32'd17);
        chk("R9", "csrrsi imm", imm, 32'h0000_6340);
        put(enc_i(12'hFFF, 5'd3, 3'd7, 5'd4, 7'h73));
        chk("R9", "csrrci cmd", {30'd0, csr_cmd}, 32'd3);
        chk("R9", "csrrci imm", imm, 32'h0000_7FFF);
        chk_illegal("R9", enc_i(12'h305, 5'd2, 3'd4, 5'd1, 7'h73));
    endtask

    task automatic t_system;
        put(32'h3020_0073);
        chk("R10", "mret", {27'd0, jump, branch, mret, fencei, wfi}, 32'b00100);
        chk("R10", "mret exc", {31'd0, exc}, 32'd0);
        put(32'h1050_0073);
        chk("R10", "wfi", {27'd0, jump, branch, mret, fencei, wfi}, 32'b00001);
        put(32'h0000_100F);
        chk("R10", "fencei", {27'd0, jump, branch, mret, fencei, wfi}, 32'b00010);
        put(32'h0FF0_000F);
        chk_quiet("R10");
        chk("R10", "fence exc", {31'd0, exc}, 32'd0);
        put(32'h0000_0073);
        chk("R11", "ecall exc", {31'd0, exc}, 32'd1);
        chk("R11", "ecall code", {28'd0, exc_code}, 32'd11);
        chk_quiet("R11");
        put(32'h0010_0073);
        chk("R11", "ebreak code", {28'd0, exc_code}, 32'd3);
        chk_quiet("R11");
    endtask

    task automatic t_illegal;
        chk_illegal("R2", 32'hDEAD_BEFF);
        chk_illegal("R1", 32'h0000_4501);
        chk("R1", "rvc flag", {31'd0, rvc}, 32'd1);
        chk_illegal("R1", 32'h0000_0000);
        chk("R1", "rvc q0", {31'd0, rvc}, 32'd1);
    endtask

    task automatic t_flags;
        for (int k = 0; k < 32; k++) begin
            put({15'h2A5A ^ 15'(k * 131), 3'(k), 5'h09, k[1:0] == 2'b11 ? 5'h1B : 5'(k), 2'b11});
            chk("R12", "onehot flags",
                {31'd0, ($countones({jump, branch, mret, fencei, wfi}) <= 1)}, 32'd1);
        end
    endtask

    logic done = 1'b0;

    initial begin
        instr = 32'h0000_0013;
        t_idle();
        t_regreg();
        t_regimm();
        t_mem();
        t_branch();
        t_upper();
        t_jump();
        t_csr();
        t_system();
        t_illegal();
        t_flags();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual running expected done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule